// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block runs the minimum-mode bus cycle of a 16-bit processor that has a 20-bit address and one set of lines shared by address and data. A request carries the address, write data, direction, memory or I/O select, byte enables and a segment code. When the block is idle it accepts the request and steps through the states T1, T2, T3 and T4. It inserts wait states when the ready input is low. The block drives the shared lines and the four upper lines, which carry the address in T1 and status afterwards. It also drives the latch, read, write, memory/IO, direction, buffer-enable and high-byte strobes. At the end of a read cycle it returns the captured data together with a one-cycle done pulse.

Tri-state pads are not modelled. An output-enable signal for the shared lines shows when the block drives them. The ready input is expected to be synchronized already by an external clock generator.

Top module: `bus_cycle_seq`

## Requirements
- R1: `reqReady` is high only in the idle state. A request is accepted on a clock edge where `reqValid` and `reqReady` are both high, and T1 starts in the next cycle. After reset `reqReady` is 1, `done` is 0 and no strobe is asserted.
- R2: `aleOut` is high for exactly one cycle per bus cycle, and that cycle is T1. Without waits, `done` rises in the fourth cycle after acceptance.
- R3: In T1 the block sets `adOut` to address bits 15:0, `upperOut` to address bits 19:16 and `adOe` to 1. It also sets `memIo` to 1 for memory and 0 for I/O, and `dtR` to 1 for a write and 0 for a read.
- R4: From T2 through T3, a read drives `rdN`=0, `wrN`=1, `denN`=0 and `adOe`=0. A write drives `wrN`=0, `rdN`=1, `denN`=0, `adOe`=1 and puts the write data on `adOut`. `rdN` and `wrN` are never low together.
- R5: From T2 through T4, `upperOut` carries status. Bit 3 is 0 and bit 2 is the `intEnable` value at acceptance. Bits 1:0 give the segment: 00 extra, 01 stack, 10 code or none, 11 data.
- R6: `ready` is sampled at the end of T2 and at the end of every wait state. Each low sample adds one wait state, and during a wait state the strobes keep their T2 values.
- R7: `rdData` takes the value of `adIn` at the clock edge that ends T3. It holds that value until the next read capture.
- R8: `reqByteEn` bit 0 selects the low byte and bit 1 the high byte. `bheN` is low from T1 through T4 when bit 1 was set, and high otherwise, including in idle.
- R9: In T4 the signals `rdN`, `wrN` and `denN` are 1, `aleOut` and `adOe` are 0, and `done` is 1 for exactly one cycle.
- R10: A `reqValid` that arrives while a cycle is running is ignored, so no further T1 follows that cycle. A request held through T4 is accepted at the first idle edge.
- R11: A synchronous `rst` during any state returns the block to idle in the next cycle with every strobe deasserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqMem | input | 1 | 1 = memory, 0 = I/O |
| reqByteEn | input | 2 | Byte enables, bit 1 = high byte |
| reqSeg | input | 2 | Segment status code |
| reqAddr | input | 20 | Cycle address |
| reqWdata | input | 16 | Write data |
| intEnable | input | 1 | Interrupt-enable flag for status |
| ready | input | 1 | Synchronized ready, low requests wait |
| adIn | input | 16 | Data returned on shared lines |
| adOut | output | 16 | Address or write data on shared lines |
| adOe | output | 1 | Shared line drive enable |
| upperOut | output | 4 | Upper address or status |
| aleOut | output | 1 | Address latch enable |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, active low |
| memIo | output | 1 | 1 = memory, 0 = I/O |
| dtR | output | 1 | 1 = transmit, 0 = receive |
| denN | output | 1 | Data buffer enable, active low |
| bheN | output | 1 | High byte enable, active low |
| reqReady | output | 1 | Idle, request can be taken |
| rdData | output | 16 | Captured read data |
| done | output | 1 | One-cycle pulse in T4 |

## Verification
Two pairs of events can fall in the same cycle. The first is the done pulse of T4 and a new request held on the inputs. The bench holds `reqValid` high through T4 and confirms three things: no new T1 starts in the next cycle, `reqReady` rises in idle, and the address of the second request appears one cycle later. The second is a reset and a wait state. The bench asserts `rst` while the cycle is stalled in Tw with `ready` low, and checks that every strobe is released in the following cycle and that no bus cycle resumes afterwards.

// File: rtl/bus_cycle_pkg.sv
package bus_cycle_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_TW   = 3'd3,
    ST_T3   = 3'd4,
    ST_T4   = 3'd5
  } busState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic addrPhase;  // T1
    logic cmdPhase;   // T2, Tw, T3
    logic capture;    // T3: read data sampled at its closing edge
    logic finish;     // T4
  } busStrobe_t;

  localparam logic [1:0] SEG_EXTRA = 2'b00;
  localparam logic [1:0] SEG_STACK = 2'b01;
  localparam logic [1:0] SEG_CODE  = 2'b10;
  localparam logic [1:0] SEG_DATA  = 2'b11;

endpackage

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl
  import bus_cycle_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       reqValid,
  input  logic       ready,
  output logic       reqReady,
  output logic       accept,
  output busStrobe_t strb
);

  busState_t state, stateNext;

  assign reqReady = (state == ST_IDLE);
  assign accept   = reqReady && reqValid;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (reqValid) stateNext = ST_T1;
      ST_T1:   stateNext = ST_T2;
      ST_T2:   stateNext = ready ? ST_T3 : ST_TW;
      ST_TW:   stateNext = ready ? ST_T3 : ST_TW;
      ST_T3:   stateNext = ST_T4;
      ST_T4:   stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  always_comb begin
    strb           = '0;
    strb.addrPhase = (state == ST_T1);
    strb.cmdPhase  = (state == ST_T2) || (state == ST_TW) || (state == ST_T3);
    strb.capture   = (state == ST_T3);
    strb.finish    = (state == ST_T4);
  end

  AST_ACCEPT_TO_T1: assert property (@(posedge clk) disable iff (rst)
    accept |=> strb.addrPhase); // R1

  AST_WAIT_ON_LOW: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_T2) || (state == ST_TW)) && !ready |=> (state == ST_TW)); // R6

  AST_T4_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    strb.finish |=> reqReady && !strb.addrPhase); // R10

endmodule

// File: rtl/bus_cycle_dp.sv
module bus_cycle_dp
  import bus_cycle_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  busStrobe_t               strb,
  input  logic                     reqWrite,
  input  logic                     reqMem,
  input  logic [DATA_W/8-1:0]      reqByteEn,
  input  logic [1:0]               reqSeg,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic [DATA_W-1:0]        reqWdata,
  input  logic                     intEnable,
  input  logic [DATA_W-1:0]        adIn,
  output logic [DATA_W-1:0]        adOut,
  output logic                     adOe,
  output logic [ADDR_W-DATA_W-1:0] upperOut,
  output logic                     aleOut,
  output logic                     rdN,
  output logic                     wrN,
  output logic                     memIo,
  output logic                     dtR,
  output logic                     denN,
  output logic                     bheN,
  output logic [DATA_W-1:0]        rdData,
  output logic                     done
);

  localparam int HI_W = ADDR_W - DATA_W;
  localparam int BE_W = DATA_W / 8;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic              writeQ;
  logic              memQ;
  logic [BE_W-1:0]   beQ;
  logic [1:0]        segQ;
  logic              ieQ;
  logic [HI_W-1:0]   statusWord;
  logic              active;
  logic              statusPhase;

  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ  <= '0;
      wdataQ <= '0;
      writeQ <= 1'b0;
      memQ   <= 1'b0;
      beQ    <= '0;
      segQ   <= SEG_EXTRA;
      ieQ    <= 1'b0;
    end else if (load) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
      writeQ <= reqWrite;
      memQ   <= reqMem;
      beQ    <= reqByteEn;
      segQ   <= reqSeg;
      ieQ    <= intEnable;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                          rdData <= '0;
    else if (strb.capture && !writeQ) rdData <= adIn;
  end

  // Status word: top bit stays 0, then interrupt flag, then segment code
  always_comb begin
    statusWord      = '0;
    statusWord[1:0] = segQ;
    statusWord[2]   = ieQ;
  end

  assign active      = strb.addrPhase || strb.cmdPhase || strb.finish;
  assign statusPhase = strb.cmdPhase || strb.finish;

  assign adOut    = strb.addrPhase ? addrQ[DATA_W-1:0] : wdataQ;
  assign adOe     = strb.addrPhase || (strb.cmdPhase && writeQ);
  assign upperOut = strb.addrPhase ? addrQ[ADDR_W-1:DATA_W] :
                    (statusPhase ? statusWord : '0);
  assign aleOut   = strb.addrPhase;
  assign rdN      = !(strb.cmdPhase && !writeQ);
  assign wrN      = !(strb.cmdPhase && writeQ);
  assign denN     = !strb.cmdPhase;
  assign memIo    = active && memQ;
  assign dtR      = active && writeQ;
  assign bheN     = !(active && beQ[BE_W-1]);
  assign done     = strb.finish;

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!rdN && !wrN)); // R4

  AST_READ_FLOAT: assert property (@(posedge clk) disable iff (rst)
    !rdN |-> !adOe); // R4

  AST_STATUS_TOP_LOW: assert property (@(posedge clk) disable iff (rst)
    statusPhase |-> !upperOut[HI_W-1]); // R5

  AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    aleOut |=> !aleOut); // R2

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9

  AST_RDDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strb.capture |=> $stable(rdData)); // R7

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bus_cycle_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     reqValid,
  input  logic                     reqWrite,
  input  logic                     reqMem,
  input  logic [DATA_W/8-1:0]      reqByteEn,
  input  logic [1:0]               reqSeg,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic [DATA_W-1:0]        reqWdata,
  input  logic                     intEnable,
  input  logic                     ready,
  input  logic [DATA_W-1:0]        adIn,
  output logic [DATA_W-1:0]        adOut,
  output logic                     adOe,
  output logic [ADDR_W-DATA_W-1:0] upperOut,
  output logic                     aleOut,
  output logic                     rdN,
  output logic                     wrN,
  output logic                     memIo,
  output logic                     dtR,
  output logic                     denN,
  output logic                     bheN,
  output logic                     reqReady,
  output logic [DATA_W-1:0]        rdData,
  output logic                     done
);

  busStrobe_t strb;
  logic       accept;

  bus_cycle_ctrl ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .reqValid (reqValid),
    .ready    (ready),
    .reqReady (reqReady),
    .accept   (accept),
    .strb     (strb)
  );

  bus_cycle_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .strb      (strb),
    .reqWrite  (reqWrite),
    .reqMem    (reqMem),
    .reqByteEn (reqByteEn),
    .reqSeg    (reqSeg),
    .reqAddr   (reqAddr),
    .reqWdata  (reqWdata),
    .intEnable (intEnable),
    .adIn      (adIn),
    .adOut     (adOut),
    .adOe      (adOe),
    .upperOut  (upperOut),
    .aleOut    (aleOut),
    .rdN       (rdN),
    .wrN       (wrN),
    .memIo     (memIo),
    .dtR       (dtR),
    .denN      (denN),
    .bheN      (bheN),
    .rdData    (rdData),
    .done      (done)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (rdN && wrN && denN && !aleOut && !adOe && !done && reqReady)); // R11

endmodule

// File: tb/bus_cycle_seq_tb.sv
module bus_cycle_seq_tb_top;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        wr;
    logic        mem;
    logic [1:0]  be;
    logic [1:0]  seg;
    logic        ie;
    logic [19:0] addr;
    logic [15:0] wdata;
    logic [15:0] rval;
    logic [3:0]  waits;
  } vec_t;

  localparam vec_t VECS [0:4] = '{
    '{1'b0, 1'b1, 2'b11, 2'b11, 1'b1, 20'hA1234, 16'h0000, 16'hBEEF, 4'd0},
    '{1'b1, 1'b1, 2'b11, 2'b01, 1'b0, 20'h5F00E, 16'hC0DE, 16'h0000, 4'd1},
    '{1'b0, 1'b0, 2'b01, 2'b10, 1'b1, 20'h003F8, 16'h0000, 16'h00A5, 4'd2},
    '{1'b1, 1'b1, 2'b10, 2'b00, 1'b1, 20'hFFFF1, 16'h7E00, 16'h0000, 4'd0},
    '{1'b0, 1'b1, 2'b11, 2'b11, 1'b0, 20'h80002, 16'h0000, 16'h1357, 4'd3}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic        reqMem = 1'b0;
  logic [1:0]  reqByteEn = '0;
  logic [1:0]  reqSeg = '0;
  logic [19:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic        intEnable = 1'b0;
  logic        ready = 1'b1;
  logic [15:0] adIn = '0;
  logic [15:0] adOut;
  logic        adOe;
  logic [3:0]  upperOut;
  logic        aleOut, rdN, wrN, memIo, dtR, denN, bheN, reqReady, done;
  logic [15:0] rdData;

  int nChecks = 0;
  int nFail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_cycle_seq dut_i (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqMem(reqMem), .reqByteEn(reqByteEn), .reqSeg(reqSeg),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .intEnable(intEnable),
    .ready(ready), .adIn(adIn), .adOut(adOut), .adOe(adOe),
    .upperOut(upperOut), .aleOut(aleOut), .rdN(rdN), .wrN(wrN),
    .memIo(memIo), .dtR(dtR), .denN(denN), .bheN(bheN),
    .reqReady(reqReady), .rdData(rdData), .done(done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic driveReq(input vec_t v);
    reqValid  = 1'b1;
    reqWrite  = v.wr;
    reqMem    = v.mem;
    reqByteEn = v.be;
    reqSeg    = v.seg;
    reqAddr   = v.addr;
    reqWdata  = v.wdata;
    intEnable = v.ie;
  endtask

  task automatic checkCmd(input vec_t v, input string st);
    chk({"R4 rdN ", st}, rdN, v.wr);
    chk({"R4 wrN ", st}, wrN, !v.wr);
    chk({"R4 denN ", st}, denN, 1'b0);
    chk({"R4 adOe ", st}, adOe, v.wr);
    if (v.wr) chk({"R4 wdata ", st}, adOut, v.wdata);
    chk({"R5 status ", st}, upperOut, {1'b0, v.ie, v.seg});
    chk({"R2 ale low ", st}, aleOut, 1'b0);
    chk({"R8 bheN ", st}, bheN, !v.be[1]);
    chk({"R9 done low ", st}, done, 1'b0);
  endtask

  // Entered at a negedge with the block idle; returns at the negedge of T4
  task automatic runToT4(input vec_t v, input bit poke, input bit holdNext, input vec_t nxt);
    driveReq(v);
    ready = 1'b0;
    adIn  = ~v.rval;
    @(negedge clk);  // T1
    reqValid = 1'b0;
    chk("R1 busy", reqReady, 1'b0);
    chk("R2 ale T1", aleOut, 1'b1);
    chk("R3 adOut", adOut, v.addr[15:0]);
    chk("R3 upper", upperOut, v.addr[19:16]);
    chk("R3 adOe", adOe, 1'b1);
    chk("R3 memIo", memIo, v.mem);
    chk("R3 dtR", dtR, v.wr);
    chk("R8 bheN T1", bheN, !v.be[1]);
    ready = (v.waits == 0);
    @(negedge clk);  // T2
    checkCmd(v, "T2");
    if (poke) begin
      reqValid = 1'b1;
      reqAddr  = 20'h0BAD0;
    end
    for (int w = 0; w < int'(v.waits); w++) begin
      @(negedge clk);  // Tw
      reqValid = 1'b0;
      checkCmd(v, "R6 Tw");
      ready = (w == int'(v.waits) - 1);
    end
    @(negedge clk);  // T3
    reqValid = 1'b0;
    checkCmd(v, "T3");
    adIn = v.rval;
    if (holdNext) driveReq(nxt);
    @(negedge clk);  // T4
    adIn = 16'hDEAD;
    chk("R9 done T4", done, 1'b1);
    chk("R9 rdN T4", rdN, 1'b1);
    chk("R9 wrN T4", wrN, 1'b1);
    chk("R9 denN T4", denN, 1'b1);
    chk("R9 adOe T4", adOe, 1'b0);
    chk("R5 status T4", upperOut, {1'b0, v.ie, v.seg});
    if (!v.wr) chk("R7 rdData", rdData, v.rval);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 reqReady reset", reqReady, 1'b1);
    chk("R1 done reset", done, 1'b0);
    chk("R1 strobes reset", {rdN, wrN, denN, aleOut, adOe, bheN}, 6'b111001);

    // Vector table
    for (int i = 0; i < 5; i++) begin
      runToT4(VECS[i], 1'b0, 1'b0, VECS[0]);
      @(negedge clk);  // idle
      chk("R1 idle", reqReady, 1'b1);
      chk("R9 done one cycle", done, 1'b0);
      chk("R8 bheN idle", bheN, 1'b1);
      if (!VECS[i].wr) chk("R7 rdData held", rdData, VECS[i].rval);
    end

    // R10: request poked while busy is ignored
    runToT4(VECS[2], 1'b1, 1'b0, VECS[0]);
    @(negedge clk);
    chk("R10 no T1 idle", aleOut, 1'b0);
    @(negedge clk);
    chk("R10 no T1 later", aleOut, 1'b0);
    chk("R10 still idle", reqReady, 1'b1);

    // R10: request held through T4 accepted at first idle edge
    runToT4(VECS[0], 1'b0, 1'b1, VECS[3]);
    @(negedge clk);
    chk("R10 no accept in T4", aleOut, 1'b0);
    chk("R10 idle after T4", reqReady, 1'b1);
    @(negedge clk);
    reqValid = 1'b0;
    chk("R10 next T1 ale", aleOut, 1'b1);
    chk("R10 next addr", adOut, VECS[3].addr[15:0]);
    ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2 done 4th cycle", done, 1'b1);
    @(negedge clk);

    // R11: reset while stalled in a wait state
    driveReq(VECS[4]);
    ready = 1'b0;
    @(negedge clk);  // T1
    reqValid = 1'b0;
    @(negedge clk);  // T2
    @(negedge clk);  // Tw
    chk("R6 stalled", rdN, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R11 strobes", {rdN, wrN, denN, aleOut, adOe, done}, 6'b111000);
    chk("R11 idle", reqReady, 1'b1);
    ready = 1'b1;
    @(negedge clk);
    chk("R11 stays idle", {aleOut, denN}, 2'b01);

    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

endmodule